// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the access stream of a processor and compares every instruction fetch, memory read, memory write and I/O port access against four programmable breakpoints. Each breakpoint has an address register, an enable bit, an access-kind selector and a byte-range selector, so one breakpoint can cover an aligned window of 1, 2, 4 or 8 bytes. When any enabled breakpoint sees an overlapping access of its kind, the unit raises a one-cycle debug trap. The trap carries a vector naming every breakpoint that matched, and the matching bits are latched into a sticky status register.

Software reaches the eight debug register indices through a privileged read/write port. Indices 4 and 5 are legacy aliases of the status and control registers. When the debug-extensions input is high, an access to either of them is refused with an invalid-opcode indication. A general-detect bit in the control register turns the unit into a guard for its own registers. With that bit set, any register access is stopped before it takes effect. The unit raises the debug trap with a general-detect cause, marks that cause in the status register and clears the general-detect bit so that a handler can then reach the registers. The stopped access can be skipped or reissued later.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset every debug register reads as zero and the outputs `trap`, `trap_hits`, `trap_gd`, `reg_done` and `reg_ud` are low.
- R2: A register access completes one cycle after `reg_req`, with `reg_done` high and, for a read, the data on `reg_rdata`. Indices 0 to 3 are the breakpoint addresses (32 bits), index 6 is status and index 7 is control. Status keeps only bits 0 to 3 and 13, control keeps bits 0 to 3, 13 and 16 to 31, and all other bits read as zero.
- R3: With `dbg_ext_en` low, index 4 reads and writes the status register and index 5 reads and writes the control register.
- R4: With `dbg_ext_en` high, an access to index 4 or 5 returns `reg_ud` high and `reg_done` low one cycle later and changes no register.
- R5: Control bits 16+4i and 17+4i give the kind of breakpoint i: 00 matches instruction fetches only, 01 matches memory writes only, 11 matches memory reads or writes, and 10 matches I/O accesses only. The access kind input is encoded as 00 fetch, 01 memory read, 10 memory write and 11 I/O.
- R6: Control bits 18+4i and 19+4i give the length of breakpoint i (00 = 1 byte, 01 = 2, 11 = 4, 10 = 8). The watched window starts at the programmed address with its low bits cleared to the length, and an access of 2^`acc_size` bytes matches when any of its bytes falls in that window.
- R7: Breakpoint i never matches while control bit i (its enable) is clear.
- R8: An access that matches raises `trap` for one cycle, starting the cycle after the access. `trap_hits` bit i is set for each breakpoint i that matched, and several bits may be set together.
- R9: A match sets status bit i and the bit stays set. Only a write to the status register clears it: the written value replaces the status, and a match in the same cycle is ORed in.
- R10: With control bit 13 set, any register access raises `trap` with `trap_gd` high one cycle later. `reg_done` stays low, no register is written, no data is returned, and status bit 13 is set.
- R11: A general-detect trap clears control bit 13 at the same edge, so the next register access completes normally.
- R12: General detect takes priority over the invalid-opcode indication. An access to index 4 or 5 with `dbg_ext_en` high and control bit 13 set gives `trap_gd` and no `reg_ud`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_ext_en | input | 1 | Debug-extensions enable; makes indices 4 and 5 refuse access |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Debug register index 0 to 7 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_done` |
| reg_done | output | 1 | Access completed |
| reg_ud | output | 1 | Access refused as invalid opcode |
| acc_valid | input | 1 | Observed access is valid this cycle |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 I/O |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | log2 of access size in bytes |
| trap | output | 1 | Debug trap, one cycle |
| trap_hits | output | 4 | Breakpoints that matched |
| trap_gd | output | 1 | Trap caused by general detect |

## Verification
If the stored kind or length field of a breakpoint is wrong, the next access near its window shows it one cycle later: a trap vector bit is missing or appears where none was expected. A sticky status bit that was lost or set by mistake cannot be seen until the status register is read, so the tests read status after each group of accesses. A general-detect bit that fails to clear would show on the following register access as a second `trap_gd` in place of `reg_done`. An alias decode error shows as data read back through the other index.

// File: rtl/bkpt_pkg.sv
// Package: shared sizes, register layout and encodings for the breakpoint unit.
// Assumes a 32-bit address space and a fixed map of eight debug register indices.
package bkpt_pkg;
    localparam int NUM_BP   = 4;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 3;
    localparam int GD_BIT   = 13;
    localparam int CFG_LSB  = 16;
    localparam int CFG_W    = 4;
    localparam logic [DATA_W-1:0] STAT_MASK = 32'h0000_200F;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFFF_200F;
    localparam logic [IDX_W-1:0]  IDX_STAT  = 3'd6;
    localparam logic [IDX_W-1:0]  IDX_CTRL  = 3'd7;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        BK_EXEC  = 2'b00,
        BK_WRITE = 2'b01,
        BK_IO    = 2'b10,
        BK_RW    = 2'b11
    } bp_kind_e;

    // Low-bit mask of a breakpoint window for a length code
    function automatic logic [ADDR_W-1:0] len_mask(input logic [1:0] code);
        case (code)
            2'b00:   return 32'd0;
            2'b01:   return 32'd1;
            2'b11:   return 32'd3;
            default: return 32'd7;
        endcase
    endfunction
endpackage

// File: rtl/bkpt_cmp.sv
// Module: one breakpoint comparator. It checks the kind filter and the byte-range
// overlap between the access and the aligned breakpoint window.
// Assumes the window never wraps past the top of the address space.
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          en,
    input  logic [1:0]    kind,
    input  logic [1:0]    len,
    input  logic [AW-1:0] base,
    input  logic          acc_valid,
    input  logic [1:0]    acc_kind,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    output logic          hit
);
    logic [AW-1:0] win_mask;
    logic [AW-1:0] acc_mask;
    logic [AW:0]   win_lo, win_hi, acc_lo, acc_hi;
    logic          kind_ok;
    logic          overlap;

    // Filter the access kind against the breakpoint kind
    always_comb begin
        case (bp_kind_e'(kind))
            BK_EXEC:  kind_ok = (acc_kind == ACC_FETCH);
            BK_WRITE: kind_ok = (acc_kind == ACC_WRITE);
            BK_RW:    kind_ok = (acc_kind == ACC_WRITE) || (acc_kind == ACC_READ);
            default:  kind_ok = (acc_kind == ACC_IO);
        endcase
    end

    // Compute both byte ranges and test them for overlap
    always_comb begin
        win_mask = len_mask(len);
        acc_mask = (AW'(1) << acc_size) - AW'(1);
        win_lo   = {1'b0, base & ~win_mask};
        win_hi   = win_lo | {1'b0, win_mask};
        acc_lo   = {1'b0, acc_addr};
        acc_hi   = acc_lo + {1'b0, acc_mask};
        overlap  = (acc_lo <= win_hi) && (win_lo <= acc_hi);
    end

    assign hit = en && acc_valid && kind_ok && overlap;
endmodule

// File: rtl/bkpt_regs.sv
// Module: debug register file and register-port decoder. It handles aliasing,
// the invalid-opcode refusal, the general-detect fault and the sticky status update.
// Assumes one register access per cycle; responses are registered one cycle later.
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dbg_ext_en,
    input  logic                          reg_req,
    input  logic                          reg_we,
    input  logic [IDX_W-1:0]              reg_idx,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic [NUM_BP-1:0]             hits,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          reg_done,
    output logic                          reg_ud,
    output logic                          gd_fire,
    output logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr,
    output logic [DATA_W-1:0]             ctrl_q,
    output logic [DATA_W-1:0]             status_q
);
    logic             is_alias;
    logic [IDX_W-1:0] eff_idx;
    logic             ud_fire;
    logic             do_acc;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] status_nxt;

    // Decode the index and the fault priority: general detect, then refusal
    always_comb begin
        is_alias = (reg_idx[2:1] == 2'b10);
        eff_idx  = is_alias ? reg_idx + 3'd2 : reg_idx;
        gd_fire  = reg_req && ctrl_q[GD_BIT];
        ud_fire  = reg_req && !gd_fire && is_alias && dbg_ext_en;
        do_acc   = reg_req && !gd_fire && !ud_fire;
    end

    // Select read data for the resolved index
    always_comb begin
        if (eff_idx < IDX_W'(NUM_BP)) rd_mux = bp_addr[eff_idx[1:0]];
        else if (eff_idx == IDX_STAT) rd_mux = status_q;
        else if (eff_idx == IDX_CTRL) rd_mux = ctrl_q;
        else                          rd_mux = '0;
    end

    // Build the next status: software write replaces, matches OR in, GD marks
    always_comb begin
        status_nxt = status_q;
        if (do_acc && reg_we && eff_idx == IDX_STAT) status_nxt = reg_wdata & STAT_MASK;
        status_nxt[NUM_BP-1:0] = status_nxt[NUM_BP-1:0] | hits;
        if (gd_fire) status_nxt[GD_BIT] = 1'b1;
    end

    // Breakpoint address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr <= '0;
        end else if (do_acc && reg_we && eff_idx < IDX_W'(NUM_BP)) begin
            bp_addr[eff_idx[1:0]] <= reg_wdata;
        end
    end

    // Control register, with general detect cleared when it fires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (gd_fire) begin
            ctrl_q[GD_BIT] <= 1'b0;
        end else if (do_acc && reg_we && eff_idx == IDX_CTRL) begin
            ctrl_q <= reg_wdata & CTRL_MASK;
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end

    // Registered port response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_done  <= 1'b0;
            reg_ud    <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_done  <= do_acc;
            reg_ud    <= ud_fire;
            reg_rdata <= (do_acc && !reg_we) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/bkpt_match_unit.sv
// Module: top of the hardware breakpoint match unit. It runs one comparator per
// breakpoint, collects their hits, and registers the trap and its cause.
// Assumes the access stream and the register port are sampled on the same clock.
module bkpt_match_unit
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_ext_en,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_done,
    output logic              reg_ud,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [31:0]       acc_addr,
    input  logic [1:0]        acc_size,
    output logic              trap,
    output logic [3:0]        trap_hits,
    output logic              trap_gd
);
    logic [NUM_BP-1:0]             hits;
    logic                          gd_fire;
    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    logic [DATA_W-1:0]             ctrl_q;
    logic [DATA_W-1:0]             status_q;

    bkpt_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_ext_en(dbg_ext_en),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .hits      (hits),
        .reg_rdata (reg_rdata),
        .reg_done  (reg_done),
        .reg_ud    (reg_ud),
        .gd_fire   (gd_fire),
        .bp_addr   (bp_addr),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q)
    );

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        localparam int CFG_POS = CFG_LSB + CFG_W * i;
        bkpt_cmp #(.AW(ADDR_W)) cmp_i (
            .en       (ctrl_q[i]),
            .kind     (ctrl_q[CFG_POS +: 2]),
            .len      (ctrl_q[CFG_POS + 2 +: 2]),
            .base     (bp_addr[i]),
            .acc_valid(acc_valid),
            .acc_kind (acc_kind),
            .acc_addr (acc_addr),
            .acc_size (acc_size),
            .hit      (hits[i])
        );
    end

    // Register the trap and its cause for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap      <= 1'b0;
            trap_hits <= '0;
            trap_gd   <= 1'b0;
        end else begin
            trap      <= (|hits) || gd_fire;
            trap_hits <= hits;
            trap_gd   <= gd_fire;
        end
    end
endmodule

// File: rtl/bkpt_match_unit_chk.sv
// Module: assertion checker for the breakpoint match unit, bound to the top.
// Assumes it sees the top's ports and its control and status registers.
module bkpt_match_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dbg_ext_en,
    input logic        reg_req,
    input logic        reg_we,
    input logic [2:0]  reg_idx,
    input logic        reg_done,
    input logic        reg_ud,
    input logic        trap,
    input logic [3:0]  trap_hits,
    input logic        trap_gd,
    input logic [31:0] ctrl_q,
    input logic [31:0] status_q
);
    logic stat_wr;
    assign stat_wr = reg_req && reg_we && (reg_idx == 3'd6 || (reg_idx == 3'd4 && !dbg_ext_en));

    p_gd_traps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && ctrl_q[13] |=> trap && trap_gd && !reg_done && !reg_ud && status_q[13]);

    p_gd_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && ctrl_q[13] |=> !ctrl_q[13]);

    p_ud_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !ctrl_q[13] && dbg_ext_en && reg_idx[2:1] == 2'b10 |=> reg_ud && !reg_done);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (status_q[3:0] & $past(status_q[3:0])) == $past(status_q[3:0]));

    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (trap_hits & ~$past(ctrl_q[3:0])) == 4'b0);

    p_hit_logged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|trap_hits) |-> (status_q[3:0] & trap_hits) == trap_hits);
endmodule

bind bkpt_match_unit bkpt_match_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_ext_en(dbg_ext_en),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_done  (reg_done),
    .reg_ud    (reg_ud),
    .trap      (trap),
    .trap_hits (trap_hits),
    .trap_gd   (trap_gd),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q)
);

// File: tb/bkpt_match_unit_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module bkpt_match_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_ext_en = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_done, reg_ud;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        trap;
    logic [3:0]  trap_hits;
    logic        trap_gd;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] r_data;
    logic        r_done, r_ud, r_trap, r_gd;
    logic [3:0]  r_hits;

    bkpt_match_unit dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // kind and length fields for breakpoint i
    function automatic logic [31:0] cfg(input int i, input logic [1:0] kind, input logic [1:0] len);
        return ({28'd0, len, kind} << (16 + 4 * i));
    endfunction

    task automatic reg_op(input logic we, input logic [2:0] idx, input logic [31:0] wd);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_idx = idx; reg_wdata = wd;
        @(negedge clk);
        r_data = reg_rdata; r_done = reg_done; r_ud = reg_ud;
        r_trap = trap; r_gd = trap_gd; r_hits = trap_hits;
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input string req, input logic [2:0] idx, input logic [31:0] wd);
        reg_op(1'b1, idx, wd);
        chk(req, {31'd0, r_done}, 32'd1);
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
        reg_op(1'b0, idx, 32'd0);
        chk(req, {31'd0, r_done}, 32'd1);
        chk(req, r_data, exp);
    endtask

    task automatic acc_chk(input string req, input logic [1:0] kind, input logic [31:0] addr,
                           input logic [1:0] size, input logic [3:0] exp_hits);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = kind; acc_addr = addr; acc_size = size;
        @(negedge clk);
        chk(req, {27'd0, trap, trap_gd, trap_hits}, {27'd0, (exp_hits != 4'd0), 1'b0, exp_hits});
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 trap", {29'd0, trap, trap_gd, reg_done}, 32'd0);
        chk("R1 hits", {27'd0, reg_ud, trap_hits}, 32'd0);
        for (int i = 0; i < 4; i++) rd_chk("R1 addr", 3'(i), 32'd0);
        rd_chk("R1 status", 3'd6, 32'd0);
        rd_chk("R1 control", 3'd7, 32'd0);
    endtask

    task automatic t_regs;
        wr("R2", 3'd0, 32'h1111_0000); wr("R2", 3'd1, 32'h2222_0001);
        wr("R2", 3'd2, 32'h3333_0002); wr("R2", 3'd3, 32'h4444_0003);
        rd_chk("R2 addr0", 3'd0, 32'h1111_0000); rd_chk("R2 addr1", 3'd1, 32'h2222_0001);
        rd_chk("R2 addr2", 3'd2, 32'h3333_0002); rd_chk("R2 addr3", 3'd3, 32'h4444_0003);
        wr("R2", 3'd7, 32'hFFFF_DFFF);
        rd_chk("R2 control mask", 3'd7, 32'hFFFF_000F);
        wr("R2", 3'd7, 32'd0);
        wr("R2", 3'd6, 32'hFFFF_FFFF);
        rd_chk("R2 status mask", 3'd6, 32'h0000_200F);
        wr("R2", 3'd6, 32'd0);
    endtask

    task automatic t_alias;
        dbg_ext_en = 1'b0;
        wr("R3", 3'd5, 32'h0001_0000);
        rd_chk("R3 idx5 to control", 3'd7, 32'h0001_0000);
        wr("R3", 3'd4, 32'h0000_0002);
        rd_chk("R3 idx4 to status", 3'd6, 32'h0000_0002);
        rd_chk("R3 read idx5", 3'd5, 32'h0001_0000);
        wr("R3", 3'd6, 32'd0); wr("R3", 3'd7, 32'd0);
    endtask

    task automatic t_ud;
        dbg_ext_en = 1'b1;
        reg_op(1'b1, 3'd5, 32'h0000_0005);
        chk("R4 ud on write", {30'd0, r_ud, r_done}, 32'd2);
        reg_op(1'b0, 3'd4, 32'd0);
        chk("R4 ud on read", {30'd0, r_ud, r_done}, 32'd2);
        chk("R4 no data", r_data, 32'd0);
        rd_chk("R4 control untouched", 3'd7, 32'd0);
        dbg_ext_en = 1'b0;
    endtask

    task automatic t_kinds;
        wr("R5", 3'd0, 32'h1000); wr("R5", 3'd1, 32'h2000);
        wr("R5", 3'd2, 32'h3000); wr("R5", 3'd3, 32'h0060);
        wr("R5", 3'd7, 32'hF | cfg(0, 2'b00, 2'b00) | cfg(1, 2'b01, 2'b00)
                          | cfg(2, 2'b11, 2'b00) | cfg(3, 2'b10, 2'b00));
        acc_chk("R5 exec fetch",   2'b00, 32'h1000, 2'd0, 4'b0001);
        acc_chk("R5 exec on read", 2'b01, 32'h1000, 2'd0, 4'b0000);
        acc_chk("R5 write hit",    2'b10, 32'h2000, 2'd0, 4'b0010);
        acc_chk("R5 write on read",2'b01, 32'h2000, 2'd0, 4'b0000);
        acc_chk("R5 rw read",      2'b01, 32'h3000, 2'd0, 4'b0100);
        acc_chk("R5 rw write",     2'b10, 32'h3000, 2'd0, 4'b0100);
        acc_chk("R5 rw on fetch",  2'b00, 32'h3000, 2'd0, 4'b0000);
        acc_chk("R5 io hit",       2'b11, 32'h0060, 2'd0, 4'b1000);
        acc_chk("R5 io on read",   2'b01, 32'h0060, 2'd0, 4'b0000);
    endtask

    task automatic t_sticky;
        rd_chk("R9 sticky bits", 3'd6, 32'h0000_000F);
        wr("R9", 3'd6, 32'h0000_0001);
        rd_chk("R9 write replaces", 3'd6, 32'h0000_0001);
        wr("R9", 3'd6, 32'd0);
        rd_chk("R9 cleared", 3'd6, 32'd0);
    endtask

    task automatic t_len;
        wr("R6", 3'd0, 32'h1003);
        wr("R6", 3'd7, 32'h5 | cfg(0, 2'b00, 2'b10) | cfg(2, 2'b11, 2'b11));
        acc_chk("R6 len8 top byte",   2'b00, 32'h1007, 2'd0, 4'b0001);
        acc_chk("R6 len8 past end",   2'b00, 32'h1008, 2'd0, 4'b0000);
        acc_chk("R6 straddle below",  2'b00, 32'h0FFF, 2'd1, 4'b0001);
        acc_chk("R6 adjacent below",  2'b00, 32'h0FF8, 2'd3, 4'b0000);
        acc_chk("R6 len4 last byte",  2'b01, 32'h3003, 2'd0, 4'b0100);
        acc_chk("R6 len4 past end",   2'b01, 32'h3004, 2'd0, 4'b0000);
        wr("R6", 3'd6, 32'd0);
    endtask

    task automatic t_enable;
        wr("R7", 3'd7, 32'h4 | cfg(0, 2'b00, 2'b10) | cfg(2, 2'b11, 2'b11));
        acc_chk("R7 disabled bp0", 2'b00, 32'h1000, 2'd0, 4'b0000);
        rd_chk("R7 no status", 3'd6, 32'd0);
    endtask

    task automatic t_multi;
        wr("R8", 3'd1, 32'h3000);
        wr("R8", 3'd7, 32'h6 | cfg(1, 2'b01, 2'b00) | cfg(2, 2'b11, 2'b11));
        acc_chk("R8 two hits", 2'b10, 32'h3000, 2'd0, 4'b0110);
        acc_chk("R8 one hit", 2'b01, 32'h3001, 2'd0, 4'b0100);
        rd_chk("R8 status both", 3'd6, 32'h0000_0006);
        wr("R8", 3'd6, 32'd0);
    endtask

    task automatic t_gd;
        wr("R10", 3'd7, 32'h0000_2000);
        reg_op(1'b1, 3'd0, 32'hDEAD_BEEF);
        chk("R10 gd trap", {27'd0, r_trap, r_gd, r_hits}, {27'd0, 1'b1, 1'b1, 4'b0});
        chk("R10 not done", {30'd0, r_done, r_ud}, 32'd0);
        rd_chk("R11 gd bit cleared", 3'd7, 32'd0);
        rd_chk("R10 status gd", 3'd6, 32'h0000_2000);
        rd_chk("R10 write dropped", 3'd0, 32'h0000_1003);
        wr("R10", 3'd6, 32'd0);
    endtask

    task automatic t_gd_prio;
        dbg_ext_en = 1'b1;
        wr("R12", 3'd7, 32'h0000_2000);
        reg_op(1'b0, 3'd4, 32'd0);
        chk("R12 gd over ud", {29'd0, r_gd, r_ud, r_done}, 32'd4);
        dbg_ext_en = 1'b0;
        rd_chk("R12 status gd", 3'd6, 32'h0000_2000);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_alias;
        t_ud;
        t_kinds;
        t_sticky;
        t_len;
        t_enable;
        t_multi;
        t_gd;
        t_gd_prio;
        report;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end
endmodule